// File: doc/BRIEF.md
# Programmable Sample Period Timer

This block produces a periodic one-cycle sample strobe that tells a data path when to refresh its output registers. A 16-bit period register sets the rate. Bit 7 of the register picks one of two time bases, and bits [6:0] hold a multiplier N. The sample period is the chosen time base multiplied by (N + 1).

Each time base is built by counting system clock cycles up to a parameterised terminal count. The defaults match a 100 MHz clock, giving 0.61035 ms and 18.921 ms. A testbench can scale the terminal counts down. Both terminal counts must be at least 2.

The block also drives a mode flag, worked out from the stored register value. Neighbouring logic uses this flag to choose the permitted serial clock speed and power state. Writing the register restarts the period from zero.

Top module: `sample_period_timer`

## Requirements
- R1: After reset the register reads 0x0001 and fast_mode is 1. The first strobe comes 2 × TB0_CYCLES cycles after the last clock edge with reset high, and strobes repeat at that period.
- R2: Bit 7 of the stored register picks the time base: 0 selects TB0_CYCLES and 1 selects TB1_CYCLES. Bits [6:0] hold N. The strobe period is (time base) × (N + 1) system clock cycles.
- R3: Bits [15:8] of wr_data are ignored. rd_data[15:8] always reads zero, and rd_data[7:0] shows the last byte written.
- R4: fast_mode is 1 exactly when the stored byte rd_data[7:0] is 0x09 or less, compared as an unsigned value. It takes its new value in the first cycle after the write edge.
- R5: A write restarts the period. The first strobe after a write edge comes exactly one new period later, and no strobe from the old setting follows the write.
- R6: sample_strobe is high for exactly one clock cycle per period.
- R7: If a write is presented in the same cycle as a strobe, that strobe is still issued, and the new period counts from that write edge.
- R8: While wr_en is low, the stored register does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Writes wr_data into the period register at the clock edge |
| wr_data | input | 16 | Write data; only bits [7:0] are kept |
| rd_data | output | 16 | Stored period register, upper byte zero |
| sample_strobe | output | 1 | One-cycle pulse once per sample period |
| fast_mode | output | 1 | 1 when the stored value is 0x09 or less |

## Verification
A register write and a sample strobe can fall in the same cycle. The bench provokes this by timing each new write for the exact cycle in which the previous setting's final expected strobe is visible. The scoreboard still expects that strobe. It then expects the next one exactly one new period after the write edge, with no stale strobe from the old setting. The bench also issues a second write part-way through a period, and it drops queued expectations that the restart cancels.

// File: rtl/sp_pkg.sv
package sp_pkg;

    localparam int unsigned REG_W      = 16;
    localparam int unsigned CFG_W      = 8;
    localparam int unsigned MULT_W     = 7;
    localparam int unsigned FAST_LIMIT = 9;

    typedef enum logic {
        TB_SHORT = 1'b0,
        TB_LONG  = 1'b1
    } tbase_e;

    typedef struct packed {
        tbase_e              base;
        logic [MULT_W-1:0]   mult;
    } period_cfg_t;

    localparam period_cfg_t CFG_RESET = '{base: TB_SHORT, mult: 7'd1};

    function automatic period_cfg_t word_to_cfg(input logic [REG_W-1:0] w);
        period_cfg_t c;
        c.base = tbase_e'(w[CFG_W-1]);
        c.mult = w[MULT_W-1:0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cfg_to_word(input period_cfg_t c);
        return {{(REG_W-CFG_W){1'b0}}, c};
    endfunction

    function automatic logic cfg_is_fast(input period_cfg_t c);
        logic [CFG_W-1:0] raw;
        raw = c;
        return (raw <= CFG_W'(FAST_LIMIT));
    endfunction

endpackage

// File: rtl/sp_cfg_reg.sv
module sp_cfg_reg
    import sp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output period_cfg_t        cfg_q,
    output logic               restart,
    output logic [REG_W-1:0]   rd_data
);

    period_cfg_t cfg_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_r <= CFG_RESET;
        end else if (wr_en) begin
            cfg_r <= word_to_cfg(wr_data);
        end
    end

    assign cfg_q   = cfg_r;
    assign restart = rst | wr_en;
    assign rd_data = cfg_to_word(cfg_r);

endmodule

// File: rtl/sp_prescaler.sv
module sp_prescaler
    import sp_pkg::*;
#(
    parameter int unsigned TB0_CYCLES = 61035,
    parameter int unsigned TB1_CYCLES = 1892100
) (
    input  logic    clk,
    input  logic    clear,
    input  tbase_e  base,
    output logic    tick
);

    localparam int unsigned TB_MAX = (TB0_CYCLES > TB1_CYCLES) ? TB0_CYCLES : TB1_CYCLES;
    localparam int unsigned CNT_W  = (TB_MAX > 2) ? $clog2(TB_MAX) : 1;
    localparam logic [CNT_W-1:0] TERM0 = CNT_W'(TB0_CYCLES - 1);
    localparam logic [CNT_W-1:0] TERM1 = CNT_W'(TB1_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term;

    generate
        if (TB0_CYCLES == TB1_CYCLES) begin : g_single_base
            assign term = TERM0;
        end else begin : g_dual_base
            assign term = (base == TB_LONG) ? TERM1 : TERM0;
        end
    endgenerate

    assign tick = (cnt_q == term);

    always_ff @(posedge clk) begin
        if (clear || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sp_period_ctr.sv
module sp_period_ctr
    import sp_pkg::*;
(
    input  logic               clk,
    input  logic               clear,
    input  logic               tick,
    input  logic [MULT_W-1:0]  mult,
    output logic               strobe
);

    logic [MULT_W-1:0] cnt_q;
    logic              last;

    assign last   = (cnt_q == mult);
    assign strobe = tick & last;

    always_ff @(posedge clk) begin
        if (clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sample_period_timer.sv
module sample_period_timer
    import sp_pkg::*;
#(
    parameter int unsigned TB0_CYCLES = 61035,
    parameter int unsigned TB1_CYCLES = 1892100
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [15:0]  wr_data,
    output logic [15:0]  rd_data,
    output logic         sample_strobe,
    output logic         fast_mode
);

    period_cfg_t cfg;
    logic        restart;
    logic        tick;

    sp_cfg_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg_q   (cfg),
        .restart (restart),
        .rd_data (rd_data)
    );

    sp_prescaler #(
        .TB0_CYCLES (TB0_CYCLES),
        .TB1_CYCLES (TB1_CYCLES)
    ) u_pre (
        .clk   (clk),
        .clear (restart),
        .base  (cfg.base),
        .tick  (tick)
    );

    sp_period_ctr u_per (
        .clk    (clk),
        .clear  (restart),
        .tick   (tick),
        .mult   (cfg.mult),
        .strobe (sample_strobe)
    );

    assign fast_mode = cfg_is_fast(cfg);

endmodule

// File: rtl/sp_timer_checker.sv
module sp_timer_checker (
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input logic [15:0]  wr_data,
    input logic [15:0]  rd_data,
    input logic         sample_strobe,
    input logic         fast_mode
);

    // R1: register holds its reset value in the first cycle after reset
    p_reset_value_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rd_data == 16'h0001));

    // R3: written low byte is kept, upper byte reads zero
    p_readback_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data == {8'h00, $past(wr_data[7:0])}));

    // R4: mode flag follows the written byte right after the write edge
    p_mode_flag_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (fast_mode == ($past(wr_data[7:0]) <= 8'd9)));

    // R5: a write restarts the period, so no strobe right after it
    p_restart_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !sample_strobe);

    // R6: strobe lasts a single cycle
    p_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        sample_strobe |=> !sample_strobe);

    // R8: no write, no change
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data));

endmodule

bind sample_period_timer sp_timer_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .sample_strobe (sample_strobe),
    .fast_mode     (fast_mode)
);

// File: tb/sample_period_timer_test.sv
module sample_period_timer_test;

    localparam int CLK_PERIOD = 10;
    localparam int TB0 = 4;
    localparam int TB1 = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0000;
    logic [15:0] rd_data;
    logic        sample_strobe;
    logic        fast_mode;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int last_exp = 0;
    logic prev_strobe = 1'b0;

    sample_period_timer #(
        .TB0_CYCLES (TB0),
        .TB1_CYCLES (TB1)
    ) uut (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .rd_data       (rd_data),
        .sample_strobe (sample_strobe),
        .fast_mode     (fast_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int period_of(input logic [15:0] v);
        return (v[7] ? TB1 : TB0) * (int'(v[6:0]) + 1);
    endfunction

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, actual, expected, cyc);
        end
    endtask

    task automatic push_strobes(input int edge_cyc, input int per, input int n);
        for (int k = 1; k <= n; k++) begin
            exp_q.push_back(edge_cyc + k * per - 1);
        end
        last_exp = edge_cyc + n * per - 1;
    endtask

    // Called at a negedge; the write takes effect at the next posedge.
    task automatic do_write(input logic [15:0] v, input int n, input logic wait_all);
        int e;
        e = cyc + 1;
        wr_en   = 1'b1;
        wr_data = v;
        while (exp_q.size() > 0 && exp_q[$] >= e) void'(exp_q.pop_back());
        push_strobes(e, period_of(v), n);
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 16'hA5A5;
        check("R3 readback", int'(rd_data), int'({8'h00, v[7:0]}));
        check("R4 mode flag", int'(fast_mode), int'(v[7:0] <= 8'd9));
        if (wait_all) begin
            while (cyc < last_exp) @(negedge clk);
            check("R8 hold", int'(rd_data), int'({8'h00, v[7:0]}));
        end
    endtask

    // Scoreboard monitor: R2 R5 R6 R7
    always @(negedge clk) begin
        if (!rst) begin
            if (sample_strobe) begin
                if (exp_q.size() == 0) begin
                    check("R5 unexpected strobe", cyc, -1);
                end else begin
                    check("R2 strobe timing", cyc, exp_q.pop_front());
                end
                if (prev_strobe) check("R6 width", 2, 1);
            end
            prev_strobe <= sample_strobe;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset value", int'(rd_data), 16'h0001);
        check("R1 fast after reset", int'(fast_mode), 1);
        rst = 1'b0;
        push_strobes(cyc, 2 * TB0, 3);
        while (cyc < last_exp) @(negedge clk);
        // R7: write in the same cycle as the final expected strobe
        check("R7 strobe at write", int'(sample_strobe), 1);
        do_write(16'hFF07, 3, 1'b1);     // R3 upper byte ignored, 32 cycles
        check("R7 strobe at write", int'(sample_strobe), 1);
        do_write(16'h0009, 2, 1'b1);     // R4 boundary: fast
        do_write(16'h000A, 1, 1'b1);     // R4 boundary: normal
        do_write(16'h0081, 3, 1'b1);     // R2 long base
        do_write(16'h0000, 4, 1'b1);     // R2 shortest period
        // R5 mid-period restart
        do_write(16'h0003, 2, 1'b0);
        repeat (9) @(negedge clk);
        do_write(16'h0002, 2, 1'b1);
        do_write(16'h007F, 1, 1'b1);
        do_write(16'h00FF, 1, 1'b1);
        repeat (3) @(negedge clk);
        check("R5 queue drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule